// File: doc/BRIEF.md
# Spaced-One-Hot Escape Transmitter

This block drives the two low-power line levels of one data lane during escape operations. On a request from the Stop level it first walks the lane through a fixed four-step entry handshake. It then shifts out an 8-bit entry command. Every bit goes out as a Mark level followed by a Space level, so the receiver can recover timing from the lines alone without a clock.

The requested mode decides what follows the command. In data mode, bytes are taken from a valid/ready interface and shifted out least significant bit first. When no byte is offered, the lane pauses at Space, and an exit request at a byte boundary ends the stream. In ultra-low-power mode the lane rests at Space until an exit request arrives. After a trigger command the block leaves at once. Each exit is signalled by a Mark-1 level and then a return to Stop.

Every line level lasts for a number of clock cycles set by `hold_i`. A setting of zero counts as one cycle.

Top module: `esc_tx`

## Requirements
- R1: After reset, and whenever idle, `line_o` is 2'b11 (Stop), `busy_o` is 0 and `ready_o` is 0.
- R2: A request with `mode_i` equal to 0 (data), 1 (ultra-low-power) or 2 (trigger) is taken from Stop. The line then shows 2'b10, 2'b00, 2'b01 and 2'b00, in that order, before the first command bit.
- R3: Every line level other than Stop and the ultra-low-power rest lasts exactly `hold_i` cycles. A `hold_i` of 0 acts as 1.
- R4: Each bit is a Mark followed by a Space (2'b00). The Mark is 2'b10 for a one and 2'b01 for a zero.
- R5: The command bits go out first bit first: 11100001 for data, 00011110 for ultra-low-power, 01100010 for trigger.
- R6: In data mode a byte is accepted only when `ready_o` and `valid_i` are both high. `ready_o` rises only at the end of the command or of a byte's last Space, or at the end of a pause period. Accepted bytes go out least significant bit first.
- R7: In data mode, at a boundary with `valid_i` low and `exit_i` low, the line holds 2'b00 for one hold period and the mode continues.
- R8: In data mode, at a boundary with `valid_i` low and `exit_i` high, the line shows 2'b10 for one hold period and then returns to Stop.
- R9: In ultra-low-power mode the line stays at 2'b00 until `exit_i` is seen high. It then shows 2'b10 for one hold period and returns to Stop.
- R10: After the trigger command the line goes straight to 2'b10 for one hold period and then to Stop.
- R11: A request with `mode_i` equal to 3 is ignored: the line stays at Stop and `busy_o` stays low.
- R12: `busy_o` is high from the cycle after a request is taken until the line is back at Stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | HOLD_W | Cycles per line level (0 acts as 1) |
| req_i | input | 1 | Start an escape operation |
| mode_i | input | 2 | 0 data, 1 ultra-low-power, 2 trigger, 3 invalid |
| exit_i | input | 1 | Leave data or ultra-low-power mode |
| data_i | input | 8 | Byte to send in data mode |
| valid_i | input | 1 | `data_i` holds a byte |
| ready_o | output | 1 | Byte taken at this clock edge if `valid_i` is high |
| line_o | output | 2 | Line levels {P, N} |
| busy_o | output | 1 | Escape operation in progress |

## Verification
The three command words are run with hold periods of 0, 1, 2 and 3 cycles. These separate bit-order errors, Mark polarity errors and hold-length errors, since each of them moves a different slot of the trace. Data mode is run in two ways. In the first, a second byte is already valid during the first byte, which shows that bytes are taken only at boundaries. In the second, bytes arrive late, so that both a pause and an exit straight after a byte are seen. The ultra-low-power rest is held for an arbitrary span before exit, and an invalid mode request is shown to leave the lane at Stop.

// File: rtl/esc_tx_pkg.sv
package esc_tx_pkg;

  localparam int unsigned SYM_W = 8;

  typedef enum logic [1:0] {
    MODE_LPDT = 2'd0,
    MODE_ULPS = 2'd1,
    MODE_TRIG = 2'd2,
    MODE_NONE = 2'd3
  } esc_mode_e;

  typedef enum logic [2:0] {
    ST_STOP, ST_ENTRY, ST_CMD, ST_BYTE, ST_PAUSE, ST_ULPS, ST_EXIT
  } esc_state_e;

  localparam logic [1:0] LN_STOP  = 2'b11;
  localparam logic [1:0] LN_M1    = 2'b10;
  localparam logic [1:0] LN_M0    = 2'b01;
  localparam logic [1:0] LN_SPACE = 2'b00;

  function automatic logic [SYM_W-1:0] cmd_code(esc_mode_e m);
    case (m)
      MODE_LPDT: cmd_code = 8'b1110_0001;
      MODE_ULPS: cmd_code = 8'b0001_1110;
      MODE_TRIG: cmd_code = 8'b0110_0010;
      default:   cmd_code = '0;
    endcase
  endfunction

endpackage

// File: rtl/esc_tx_timer.sv
module esc_tx_timer #(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              tick_o
);

  logic [HOLD_W-1:0] cnt_q;

  // hold of 0 loads 0, so it behaves as 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= (hold_i == '0) ? '0 : hold_i - 1'b1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);

endmodule

// File: rtl/esc_tx_ser.sv
module esc_tx_ser
  import esc_tx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         msb_first_i,
  input  logic         step_i,
  output logic [1:0]   line_o,
  output logic         last_o
);

  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]     sh_q;
  logic [IDX_W-1:0] idx_q;
  logic             space_q;
  logic             msb_q;
  logic             cur_bit;

  assign cur_bit = msb_q ? sh_q[W-1] : sh_q[0];
  assign line_o  = space_q ? LN_SPACE : (cur_bit ? LN_M1 : LN_M0);
  assign last_o  = space_q && (idx_q == IDX_W'(W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      idx_q   <= '0;
      space_q <= 1'b0;
      msb_q   <= 1'b0;
    end else if (load_i) begin
      sh_q    <= word_i;
      idx_q   <= '0;
      space_q <= 1'b0;
      msb_q   <= msb_first_i;
    end else if (step_i) begin
      if (!space_q) begin
        space_q <= 1'b1;
      end else begin
        space_q <= 1'b0;
        idx_q   <= idx_q + 1'b1;
        sh_q    <= msb_q ? (sh_q << 1) : (sh_q >> 1);
      end
    end
  end

  AST_MARK_THEN_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !space_q) |=> (line_o == LN_SPACE)); // R4

endmodule

// File: rtl/esc_tx.sv
module esc_tx
  import esc_tx_pkg::*;
#(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              req_i,
  input  logic [1:0]        mode_i,
  input  logic              exit_i,
  input  logic [SYM_W-1:0]  data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic [1:0]        line_o,
  output logic              busy_o
);

  esc_state_e state_q, state_d;
  esc_mode_e  mode_q, mode_d;
  logic [1:0] entry_q, entry_d;

  logic             tick, tmr_load;
  logic             ser_load, ser_msb, ser_step, ser_last;
  logic [SYM_W-1:0] ser_word;
  logic [1:0]       ser_line;
  logic             boundary;

  esc_tx_timer #(.HOLD_W(HOLD_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .hold_i (hold_i),
    .tick_o (tick)
  );

  esc_tx_ser #(.W(SYM_W)) i_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ser_load),
    .word_i      (ser_word),
    .msb_first_i (ser_msb),
    .step_i      (ser_step),
    .line_o      (ser_line),
    .last_o      (ser_last)
  );

  assign boundary = tick && ((state_q == ST_CMD && ser_last && mode_q == MODE_LPDT) ||
                             (state_q == ST_BYTE && ser_last) ||
                             (state_q == ST_PAUSE));
  assign ready_o  = boundary;
  assign busy_o   = (state_q != ST_STOP);

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    entry_d  = entry_q;
    tmr_load = 1'b0;
    ser_load = 1'b0;
    ser_step = 1'b0;
    ser_msb  = 1'b1;
    ser_word = cmd_code(mode_q);
    case (state_q)
      ST_STOP: if (req_i && mode_i != MODE_NONE) begin
        state_d  = ST_ENTRY;
        entry_d  = 2'd0;
        mode_d   = esc_mode_e'(mode_i);
        tmr_load = 1'b1;
      end
      ST_ENTRY: if (tick) begin
        tmr_load = 1'b1;
        if (entry_q == 2'd3) begin
          state_d  = ST_CMD;
          ser_load = 1'b1;
        end else begin
          entry_d = entry_q + 2'd1;
        end
      end
      ST_CMD, ST_BYTE: if (tick) begin
        if (!ser_last) begin
          ser_step = 1'b1;
          tmr_load = 1'b1;
        end else if (state_q == ST_CMD && mode_q == MODE_ULPS) begin
          state_d = ST_ULPS;
        end else if (state_q == ST_CMD && mode_q == MODE_TRIG) begin
          state_d  = ST_EXIT;
          tmr_load = 1'b1;
        end
      end
      ST_ULPS: if (exit_i) begin
        state_d  = ST_EXIT;
        tmr_load = 1'b1;
      end
      ST_EXIT: if (tick) state_d = ST_STOP;
      default: ;
    endcase
    // data-mode byte boundary: take a byte, leave, or pause
    if (boundary) begin
      tmr_load = 1'b1;
      if (valid_i) begin
        state_d  = ST_BYTE;
        ser_load = 1'b1;
        ser_word = data_i;
        ser_msb  = 1'b0;
      end else if (exit_i) begin
        state_d = ST_EXIT;
      end else begin
        state_d = ST_PAUSE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STOP;
      mode_q  <= MODE_LPDT;
      entry_q <= 2'd0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      entry_q <= entry_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_ENTRY: case (entry_q)
        2'd0:    line_o = LN_M1;
        2'd2:    line_o = LN_M0;
        default: line_o = LN_SPACE;
      endcase
      ST_CMD, ST_BYTE:   line_o = ser_line;
      ST_PAUSE, ST_ULPS: line_o = LN_SPACE;
      ST_EXIT:           line_o = LN_M1;
      default:           line_o = LN_STOP;
    endcase
  end

  AST_LINE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q inside {ST_ENTRY, ST_CMD, ST_BYTE, ST_PAUSE, ST_EXIT}) && !tick) |=> $stable(line_o)); // R3
  AST_BYTE_LSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && valid_i) |=> (line_o == ($past(data_i[0]) ? LN_M1 : LN_M0))); // R6
  AST_ENTRY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (line_o == LN_M1)); // R2
  AST_EXIT_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(line_o) == LN_M1)); // R8

endmodule

// File: tb/test_esc_tx.sv
`timescale 1ns/1ps
module test_esc_tx;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] hold_i = 8'd1;
  logic       req_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       exit_i = 1'b0;
  logic [7:0] data_i = 8'd0;
  logic       valid_i = 1'b0;
  logic       ready_o;
  logic [1:0] line_o;
  logic       busy_o;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] byte_q [4];
  int n_bytes = 0;
  int feed_idx = 0;
  int n_acc = 0;

  always #2.5 clk_i = ~clk_i;

  esc_tx i_esc_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .req_i(req_i),
    .mode_i(mode_i), .exit_i(exit_i), .data_i(data_i), .valid_i(valid_i),
    .ready_o(ready_o), .line_o(line_o), .busy_o(busy_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // check line for n cycles; service the byte feed on accepts
  task automatic expect_line(input logic [1:0] v, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic acc;
      chk(line_o === v, req, {30'd0, line_o}, {30'd0, v});
      acc = ready_o && valid_i;
      @(negedge clk_i);
      if (acc) begin
        n_acc++;
        feed_idx++;
        if (feed_idx < n_bytes) data_i = byte_q[feed_idx];
        else valid_i = 1'b0;
      end
    end
  endtask

  task automatic expect_word(input logic [7:0] w, input logic msb, input int h, input string req);
    for (int i = 0; i < 8; i++) begin
      logic b;
      b = msb ? w[7-i] : w[i];
      expect_line(b ? 2'b10 : 2'b01, h, req);   // R4 mark
      expect_line(2'b00, h, "R4 space");
    end
  endtask

  task automatic start(input logic [1:0] m, input logic [7:0] h_in, input int h);
    hold_i = h_in;
    mode_i = m;
    req_i  = 1'b1;
    @(negedge clk_i);
    req_i  = 1'b0;
    chk(busy_o === 1'b1, "R12 busy after request", {31'd0, busy_o}, 32'd1);
    expect_line(2'b10, h, "R2 entry 1");
    expect_line(2'b00, h, "R2 entry 2");
    expect_line(2'b01, h, "R2 entry 3");
    expect_line(2'b00, h, "R2 entry 4");
  endtask

  task automatic check_idle(input string req);
    chk(line_o === 2'b11, req, {30'd0, line_o}, 32'h3);
    chk(busy_o === 1'b0, req, {31'd0, busy_o}, 32'd0);
    chk(ready_o === 1'b0, req, {31'd0, ready_o}, 32'd0);
  endtask

  task automatic t_reset;
    check_idle("R1 reset state");
  endtask

  task automatic t_ignore;
    mode_i = 2'd3;
    req_i  = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      check_idle("R11 invalid mode ignored");
    end
    req_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_trig(input logic [7:0] h_in, input int h);
    start(2'd2, h_in, h);
    expect_word(8'b0110_0010, 1'b1, h, "R5 trigger command R3");
    expect_line(2'b10, h, "R10 exit after trigger");
    check_idle("R12 idle after trigger");
  endtask

  task automatic t_ulps;
    start(2'd1, 8'd2, 2);
    expect_word(8'b0001_1110, 1'b1, 2, "R5 ulps command");
    expect_line(2'b00, 11, "R9 ulps rest");
    exit_i = 1'b1;
    expect_line(2'b00, 1, "R9 ulps rest at exit");
    exit_i = 1'b0;
    expect_line(2'b10, 2, "R9 ulps exit mark");
    check_idle("R9 back to stop");
  endtask

  task automatic t_data_stream;
    byte_q[0] = 8'hA5; byte_q[1] = 8'h3C;
    n_bytes = 2; feed_idx = 0; n_acc = 0;
    data_i = byte_q[0]; valid_i = 1'b1;
    start(2'd0, 8'd2, 2);
    expect_word(8'b1110_0001, 1'b1, 2, "R5 data command");
    expect_word(8'hA5, 1'b0, 2, "R6 byte 0 lsb first");
    expect_word(8'h3C, 1'b0, 2, "R6 byte 1 lsb first");
    expect_line(2'b00, 2, "R7 pause 1");
    exit_i = 1'b1;
    expect_line(2'b00, 2, "R7 pause 2");
    exit_i = 1'b0;
    expect_line(2'b10, 2, "R8 exit mark");
    check_idle("R8 back to stop");
    chk(n_acc == 2, "R6 accepted bytes", n_acc, 32'd2);
  endtask

  task automatic t_data_late;
    n_bytes = 1; feed_idx = 0; n_acc = 0; valid_i = 1'b0;
    start(2'd0, 8'd1, 1);
    expect_word(8'b1110_0001, 1'b1, 1, "R5 data command");
    expect_line(2'b00, 2, "R7 pause waiting");
    byte_q[0] = 8'h96; data_i = 8'h96; valid_i = 1'b1; exit_i = 1'b1;
    expect_line(2'b00, 1, "R7 pause before accept");
    expect_word(8'h96, 1'b0, 1, "R6 late byte");
    exit_i = 1'b0;
    expect_line(2'b10, 1, "R8 exit after byte");
    check_idle("R8 back to stop");
    chk(n_acc == 1, "R6 accepted bytes", n_acc, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ignore();
    t_trig(8'd3, 3);
    t_trig(8'd0, 1);
    t_ulps();
    t_data_stream();
    t_data_late();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule